// File: doc/BRIEF.md
# Gated 1:20 Deserializer With Mute

This block turns a recovered serial stream, one bit per cycle of a fast bit clock, into 20-bit parallel words. A free-running divide-by-20 counter, started by reset, decides where each group of bits begins. No search for a word boundary and no descrambling take place, so downstream logic must align and descramble the words itself. Beside each word the block drives a one-cycle valid pulse and a divided parallel clock at one twentieth of the bit rate.

A lock status input gates the parallel output. When lock is low at the end of a group, the previous word stays on the output and no valid pulse appears. The parallel clock keeps running whatever the lock state is. A separate serial loop-through output carries either the retimed bit, one bit clock late, or the raw input bit with no register in the path. Muting never touches this output, and an enable input forces it low when the loop-through is not wanted.

Top module: `par_deser_mute`

## Requirements
- R1: While reset is asserted, `pword` is all zeros, `pword_vld` is 0 and `pclk_out` is 1.
- R2: The divide counter is 0 on the first bit clock after reset release, and every 20 bit clocks from then on form one group. The first bit of a group lands in `pword[19]` and the twentieth in `pword[0]`.
- R3: A new word appears on `pword`, with `pword_vld` high for exactly one cycle, in the cycle after the bit clock edge that takes in the twentieth bit of a group. This happens only when `lock_in` is 1 on that edge.
- R4: When `lock_in` is 0 on the edge that ends a group, `pword` keeps its previous value and `pword_vld` stays 0. The value of `lock_in` at other edges has no effect on the words.
- R5: `pclk_out` is high for 10 bit clocks and low for 10 bit clocks, whatever `lock_in` is. It rises in the same cycle that `pword_vld` pulses.
- R6: With `loop_oe` = 1 and `retime_sel` = 1, `loop_dout` equals the `ser_din` value taken in at the previous bit clock edge.
- R7: With `loop_oe` = 1 and `retime_sel` = 0, `loop_dout` follows `ser_din` with no register in the path, whatever `lock_in` is.
- R8: With `loop_oe` = 0, `loop_dout` is 0.
- R9: Groups follow one another with no gap. While lock is held, `pword_vld` pulses once every 20 bit clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| ser_din | input | 1 | Recovered serial data bit |
| lock_in | input | 1 | Lock status; 1 lets words through, 0 mutes the parallel output |
| retime_sel | input | 1 | Loop-through source: 1 = retimed bit, 0 = raw input bit |
| loop_oe | input | 1 | Loop-through enable; 0 forces `loop_dout` low |
| pword | output | 20 | Assembled parallel word; bit 19 holds the earliest bit |
| pword_vld | output | 1 | One-cycle pulse when `pword` takes a new word |
| pclk_out | output | 1 | Parallel clock, bit clock divided by 20 |
| loop_dout | output | 1 | Serial loop-through output |

## Verification
Two things can fall in the same bit clock and are exercised together. The first is a group ending in the very cycle that lock drops. The bench holds lock high for nineteen bits of a word and lowers it only for the twentieth, and expects the old word to stay on `pword` with no valid pulse, while `pclk_out` keeps its 10/10 rhythm. The second is a mute that lasts a whole word while the loop-through runs in bypass. The bench checks `loop_dout` against the raw input bit after every bit, and at the same time checks that the parallel output stays frozen. It also runs the opposite case, where lock drops in the middle of a group but returns before the group ends, and expects that word to come through.

// File: rtl/deser_pkg.sv
package deser_pkg;

  typedef enum logic {
    LOOP_RAW     = 1'b0,
    LOOP_RETIMED = 1'b1
  } loop_src_e;

  function automatic int unsigned half_period(input int unsigned div);
    return div / 2;
  endfunction

endpackage

// File: rtl/deser_divider.sv
module deser_divider #(
  parameter int unsigned DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap_o,
  output logic pclk_o
);
  import deser_pkg::*;

  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(half_period(DIV));

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pclk_q, pclk_d;
  logic          cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    pclk_d = pclk_q;
    if (cnt_en) begin
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      pclk_d = (cnt_d < HALF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign wrap_o = (cnt_q == LAST);
  assign pclk_o = pclk_q;

  // R5
  pclk_edge_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (pclk_q != $past(pclk_q))) |-> (cnt_q == '0 || cnt_q == HALF));

endmodule

// File: rtl/deser_shifter.sv
module deser_shifter #(
  parameter int unsigned W            = 20,
  parameter bit          FIRST_TO_MSB = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] sr_q, sr_d;
  logic         shift_en;

  assign shift_en = 1'b1;

  generate
    if (FIRST_TO_MSB) begin : g_msb_first
      assign word_o = {sr_q[W-2:0], bit_i};
    end else begin : g_lsb_first
      assign word_o = {bit_i, sr_q[W-1:1]};
    end
  endgenerate

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = word_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/deser_hold.sv
module deser_hold #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap_i,
  input  logic         lock_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] pword_o,
  output logic         vld_o
);

  logic [W-1:0] pword_q, pword_d;
  logic         vld_q, vld_d;
  logic         upd_en;

  assign upd_en = wrap_i & lock_i;

  always_comb begin
    pword_d = pword_q;
    vld_d   = 1'b0;
    if (upd_en) begin
      pword_d = word_i;
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pword_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      pword_q <= pword_d;
      vld_q   <= vld_d;
    end
  end

  assign pword_o = pword_q;
  assign vld_o   = vld_q;

  // R4
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !lock_i) |=> ($stable(pword_q) && !vld_q));

endmodule

// File: rtl/deser_loopthru.sv
module deser_loopthru (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  input  logic sel_i,
  input  logic oe_i,
  output logic dout_o
);
  import deser_pkg::*;

  logic      din_q;
  loop_src_e src;

  assign src = loop_src_e'(sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din_i;
  end

  always_comb begin
    dout_o = 1'b0;
    if (oe_i) dout_o = (src == LOOP_RETIMED) ? din_q : din_i;
  end

endmodule

// File: rtl/par_deser_mute.sv
module par_deser_mute #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_din,
  input  logic         lock_in,
  input  logic         retime_sel,
  input  logic         loop_oe,
  output logic [W-1:0] pword,
  output logic         pword_vld,
  output logic         pclk_out,
  output logic         loop_dout
);

  logic         wrap;
  logic [W-1:0] asm_word;

  deser_divider #(.DIV(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_o (wrap),
    .pclk_o (pclk_out)
  );

  deser_shifter #(.W(W), .FIRST_TO_MSB(1'b1)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_i  (ser_din),
    .word_o (asm_word)
  );

  deser_hold #(.W(W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap_i  (wrap),
    .lock_i  (lock_in),
    .word_i  (asm_word),
    .pword_o (pword),
    .vld_o   (pword_vld)
  );

  deser_loopthru u_loop (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (ser_din),
    .sel_i  (retime_sel),
    .oe_i   (loop_oe),
    .dout_o (loop_dout)
  );

  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pword_vld |=> !pword_vld);

  // R5
  vld_on_pclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pword_vld |-> (pclk_out && !$past(pclk_out)));

  // R6
  retimed_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_oe && retime_sel && $past(rst_n)) |-> (loop_dout == $past(ser_din)));

endmodule

// File: tb/par_deser_mute_bench.sv
module par_deser_mute_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_din, lock_in, retime_sel, loop_oe;
  logic [W-1:0] pword;
  logic         pword_vld, pclk_out, loop_dout;

  int           n_checks = 0;
  int           n_fail   = 0;
  int           edges    = 0;
  bit           mon_on   = 1'b0;
  bit           done     = 1'b0;
  logic         prev_din = 1'b0;
  logic [W-1:0] held     = '0;
  logic [W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  par_deser_mute #(.W(W)) u_par_deser_mute (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_din    (ser_din),
    .lock_in    (lock_in),
    .retime_sel (retime_sel),
    .loop_oe    (loop_oe),
    .pword      (pword),
    .pword_vld  (pword_vld),
    .pclk_out   (pclk_out),
    .loop_dout  (loop_dout)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) if (rst_n === 1'b1) edges++;

  // monitor: pops the scoreboard and checks parallel outputs
  always @(negedge clk) begin
    if (mon_on) begin
      chk(pclk_out === ((edges % W) < W/2), "R5 pclk rhythm", 32'(pclk_out), 32'((edges % W) < W/2));
      if (pword_vld === 1'b1) begin
        chk((edges % W) == 0, "R9 vld spacing", 32'(edges % W), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected word", 32'(pword), 32'(held));
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(pword === e, "R2 R3 word content", 32'(pword), 32'(e));
          held = e;
        end
      end else begin
        chk(pword === held, "R4 held word", 32'(pword), 32'(held));
      end
    end
  end

  // drives one bit, checks the loop-through, waits for the next falling edge
  task automatic drive_bit(input logic b, input logic lk, input logic sel, input logic oe);
    logic e;
    ser_din = b; lock_in = lk; retime_sel = sel; loop_oe = oe;
    #1;
    e = oe ? (sel ? prev_din : b) : 1'b0;
    if (!oe)      chk(loop_dout === e, "R8 loop disabled", 32'(loop_dout), 32'(e));
    else if (sel) chk(loop_dout === e, "R6 loop retimed", 32'(loop_dout), 32'(e));
    else          chk(loop_dout === e, "R7 loop bypass", 32'(loop_dout), 32'(e));
    prev_din = b;
    @(negedge clk);
  endtask

  // mode 0: locked, 1: unlocked all word, 2: lock drops only on last bit,
  // 3: lock drops mid word but is high on the last bit
  task automatic send_word(input logic [W-1:0] w, input int mode, input logic sel, input logic oe);
    for (int i = 0; i < W; i++) begin
      logic lk;
      case (mode)
        1:       lk = 1'b0;
        2:       lk = (i != W-1);
        3:       lk = !(i >= 5 && i < 12);
        default: lk = 1'b1;
      endcase
      if (i == W-1 && lk) exp_q.push_back(w);
      drive_bit(w[W-1-i], lk, sel, oe);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ser_din = 1'b1; lock_in = 1'b0; retime_sel = 1'b1; loop_oe = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pword === '0, "R1 reset word", 32'(pword), 32'd0);
    chk(pword_vld === 1'b0, "R1 reset vld", 32'(pword_vld), 32'd0);
    chk(pclk_out === 1'b1, "R1 reset pclk", 32'(pclk_out), 32'd1);
    ser_din = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R2 R3 R9 back-to-back locked words, retimed loop-through (R6)
    send_word(20'hA5C3F, 0, 1'b1, 1'b1);
    send_word(20'h80000, 0, 1'b1, 1'b1);
    send_word(20'h00001, 0, 1'b1, 1'b1);
    send_word(20'hFFFFF, 0, 1'b1, 1'b1);
    // R4 lock falls in the very cycle the group ends
    send_word(20'h12345, 2, 1'b1, 1'b1);
    // R4 R7 muted word while loop-through bypasses the retimer
    send_word(20'h0F0F0, 1, 1'b0, 1'b1);
    // R4 lock dip mid word, high at group end: word passes
    send_word(20'h3C3C3, 3, 1'b0, 1'b1);
    // R8 loop-through disabled, parallel path unaffected
    send_word(20'h55555, 0, 1'b1, 1'b0);
    send_word(20'hDEADB, 0, 1'b0, 1'b1);
    send_word(20'h00000, 0, 1'b1, 1'b1);
    send_word(20'h6B1E9, 1, 1'b1, 1'b1);
    repeat (3) drive_bit(1'b0, 1'b1, 1'b1, 1'b1);
    // R3 every pushed word must have been issued
    chk(exp_q.size() == 0, "R3 words outstanding", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end

endmodule